// File: doc/BRIEF.md
# Record/Playback Sequencer for a Pointer-Addressed Sample Buffer

This block is the control sequencer of a record and playback appliance. The sample storage is a separate buffer with its own write and read pointers, and this block drives it. While idle it keeps everything frozen. A record request starts a session that first clears the buffer's write pointer and then streams samples into the buffer. A play request clears the read pointer and then streams samples out. A stop request ends either session.

Samples move on a sample enable pulse. Inside a session, each enable cycle produces a one-cycle strobe for the side that is active: the write strobe while recording, the read strobe while playing. Each enable cycle also advances a shared sample counter. The buffer takes a sample on a write strobe while write enable is high, and it presents the next sample after each read strobe. All strobes are ordinary data signals at the system clock rate. They are not gated clocks.

Top module: `rec_play_seq`

## Requirements
- R1: After an asynchronous reset the block is idle. In idle, the outputs are `cnt_clr_o`=1 and every other output 0.
- R2: In idle, with neither `rec_i` nor `play_i` high, the block stays idle. `stop_i` has no effect in idle.
- R3: In idle, `rec_i` moves the block to a write-pointer-reset state for exactly one cycle. In that state `wptr_rst_o`=1 and all other outputs are 0. The block then enters record.
- R4: In idle, `play_i` (with `rec_i` low) moves the block to a read-pointer-reset state for exactly one cycle. In that state `rptr_rst_o`=1 and all other outputs are 0. The block then enters play.
- R5: If `rec_i` and `play_i` are both high in idle, record wins.
- R6: In record: `wr_en_o`=1, `wclk_stb_o`=`smp_en_i`, `cnt_stb_o`=`smp_en_i`, and `rclk_stb_o`, `cnt_clr_o`, `wptr_rst_o`, `rptr_rst_o` are all 0.
- R7: In play: `rclk_stb_o`=`smp_en_i`, `cnt_stb_o`=`smp_en_i`, and `wr_en_o`, `wclk_stb_o`, `cnt_clr_o`, `wptr_rst_o`, `rptr_rst_o` are all 0.
- R8: In record or play, `stop_i`=1 returns the block to idle on the next clock edge. Otherwise the block stays in its session, and `rec_i` and `play_i` are ignored.
- R9: No strobe output is high while `smp_en_i` is 0. `wclk_stb_o` and `rclk_stb_o` are never high together.
- R10: `stop_i` has no effect in either pointer-reset state. The session always starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_i | input | 1 | Record request |
| play_i | input | 1 | Play request |
| stop_i | input | 1 | Stop request |
| smp_en_i | input | 1 | Sample enable, one cycle per sample |
| wr_en_o | output | 1 | Buffer write enable |
| wptr_rst_o | output | 1 | Buffer write-pointer reset |
| rptr_rst_o | output | 1 | Buffer read-pointer reset |
| wclk_stb_o | output | 1 | Buffer write strobe |
| rclk_stb_o | output | 1 | Buffer read strobe |
| cnt_stb_o | output | 1 | Sample counter advance |
| cnt_clr_o | output | 1 | Sample counter clear |

## Verification
The two functions that can fall in the same cycle are the session exit on stop and the last sample strobe. The bench provokes this by raising `stop_i` and `smp_en_i` together while recording. It samples the outputs before the clock edge and expects the write strobe to fire in that cycle. After the edge it expects idle outputs. A second case pairs `stop_i` with the cycle spent in the pointer-reset state, and expects the session to start anyway.

// File: rtl/rec_play_pkg.sv
package rec_play_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WRST = 3'd1,
    ST_REC  = 3'd2,
    ST_RRST = 3'd3,
    ST_PLAY = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic wr_en;
    logic wptr_rst;
    logic rptr_rst;
    logic wstb;
    logic rstb;
    logic cstb;
    logic cclr;
  } seq_out_t;
endpackage

// File: rtl/rec_play_fsm.sv
module rec_play_fsm
  import rec_play_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rec_i,
  input  logic       play_i,
  input  logic       stop_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rec_i)       state_d = ST_WRST;  // record has priority
        else if (play_i) state_d = ST_RRST;
      end
      ST_WRST: state_d = ST_REC;
      ST_RRST: state_d = ST_PLAY;
      ST_REC, ST_PLAY: if (stop_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rec_play_decode.sv
module rec_play_decode
  import rec_play_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       smp_en_i,
  output seq_out_t   out_o
);
  always_comb begin
    out_o = '0;
    unique case (state_i)
      ST_IDLE: out_o.cclr = 1'b1;
      ST_WRST: out_o.wptr_rst = 1'b1;
      ST_RRST: out_o.rptr_rst = 1'b1;
      ST_REC: begin
        out_o.wr_en = 1'b1;
        out_o.wstb  = smp_en_i;
        out_o.cstb  = smp_en_i;
      end
      ST_PLAY: begin
        out_o.rstb = smp_en_i;
        out_o.cstb = smp_en_i;
      end
      default: out_o.cclr = 1'b1;
    endcase
  end
endmodule

// File: rtl/rec_play_seq.sv
module rec_play_seq
  import rec_play_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rec_i,
  input  logic play_i,
  input  logic stop_i,
  input  logic smp_en_i,
  output logic wr_en_o,
  output logic wptr_rst_o,
  output logic rptr_rst_o,
  output logic wclk_stb_o,
  output logic rclk_stb_o,
  output logic cnt_stb_o,
  output logic cnt_clr_o
);
  seq_state_e state;
  seq_out_t   outs;

  rec_play_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rec_i   (rec_i),
    .play_i  (play_i),
    .stop_i  (stop_i),
    .state_o (state)
  );

  rec_play_decode u_dec (
    .state_i  (state),
    .smp_en_i (smp_en_i),
    .out_o    (outs)
  );

  assign wr_en_o    = outs.wr_en;
  assign wptr_rst_o = outs.wptr_rst;
  assign rptr_rst_o = outs.rptr_rst;
  assign wclk_stb_o = outs.wstb;
  assign rclk_stb_o = outs.rstb;
  assign cnt_stb_o  = outs.cstb;
  assign cnt_clr_o  = outs.cclr;
endmodule

// File: rtl/rec_play_seq_chk.sv
module rec_play_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rec_i,
  input logic play_i,
  input logic stop_i,
  input logic smp_en_i,
  input logic wr_en_o,
  input logic wptr_rst_o,
  input logic rptr_rst_o,
  input logic wclk_stb_o,
  input logic rclk_stb_o,
  input logic cnt_stb_o,
  input logic cnt_clr_o
);
  p_idle_stay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_clr_o && !rec_i && !play_i) |=> cnt_clr_o);

  p_wrst_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_rst_o |=> (!wptr_rst_o && wr_en_o));

  p_rrst_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_rst_o |=> (!rptr_rst_o && !wr_en_o && !cnt_clr_o));

  p_rec_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_clr_o && rec_i) |=> wptr_rst_o);

  p_rec_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && smp_en_i) |-> (wclk_stb_o && cnt_stb_o && !rclk_stb_o));

  p_stop_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_o || rclk_stb_o) && stop_i) |=> cnt_clr_o);

  p_stb_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wclk_stb_o || rclk_stb_o || cnt_stb_o) |-> smp_en_i);

  p_stb_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wclk_stb_o && rclk_stb_o));
endmodule

bind rec_play_seq rec_play_seq_chk u_chk (.*);

// File: tb/sim_rec_play_seq.sv
`timescale 1ns/1ps
module sim_rec_play_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec = 1'b0, play = 1'b0, stop = 1'b0, en = 1'b0;
  logic wr_en, wptr_rst, rptr_rst, wstb, rstb, cstb, cclr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rec_play_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .rec_i(rec), .play_i(play), .stop_i(stop),
    .smp_en_i(en), .wr_en_o(wr_en), .wptr_rst_o(wptr_rst), .rptr_rst_o(rptr_rst),
    .wclk_stb_o(wstb), .rclk_stb_o(rstb), .cnt_stb_o(cstb), .cnt_clr_o(cclr)
  );

  // output order: wr_en wptr_rst rptr_rst wstb rstb cstb cclr
  localparam logic [6:0] O_IDLE = 7'b0000001;
  localparam logic [6:0] O_WRST = 7'b0100000;
  localparam logic [6:0] O_RRST = 7'b0010000;
  localparam logic [6:0] O_REC1 = 7'b1001010;
  localparam logic [6:0] O_REC0 = 7'b1000000;
  localparam logic [6:0] O_PLY1 = 7'b0000110;
  localparam logic [6:0] O_PLY0 = 7'b0000000;

  // {rec, play, stop, en, expected after edge, requirement number}
  localparam int NV = 19;
  localparam logic [18:0] VEC [NV] = '{
    {4'b0011, O_IDLE, 8'd2},   // R2 stop ignored in idle
    {4'b0001, O_IDLE, 8'd2},   // R2
    {4'b1000, O_WRST, 8'd3},   // R3
    {4'b0000, O_REC0, 8'd3},   // R3 then record
    {4'b0001, O_REC1, 8'd6},   // R6
    {4'b0101, O_REC1, 8'd8},   // R8 play ignored
    {4'b0011, O_IDLE, 8'd8},   // R8 stop
    {4'b0101, O_RRST, 8'd4},   // R4
    {4'b0001, O_PLY1, 8'd7},   // R7
    {4'b0000, O_PLY0, 8'd9},   // R9 no strobe without enable
    {4'b1001, O_PLY1, 8'd8},   // R8 rec ignored
    {4'b0010, O_IDLE, 8'd8},   // R8
    {4'b1101, O_WRST, 8'd5},   // R5 record wins
    {4'b0011, O_REC1, 8'd10},  // R10 stop in write reset
    {4'b0011, O_IDLE, 8'd8},
    {4'b0110, O_RRST, 8'd4},
    {4'b0010, O_PLY0, 8'd10},  // R10 stop in read reset
    {4'b0001, O_PLY1, 8'd7},
    {4'b0011, O_IDLE, 8'd8}
  };

  function automatic logic [6:0] outs();
    return {wr_en, wptr_rst, rptr_rst, wstb, rstb, cstb, cclr};
  endfunction

  task automatic check(input logic [6:0] exp, input int req, input string tag);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %b expected %b", req, tag, outs(), exp);
    end
  endtask

  task automatic step(input logic [3:0] in);
    @(negedge clk);
    {rec, play, stop, en} = in;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1 check(O_IDLE, 1, "in reset");          // R1
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 check(O_IDLE, 1, "after reset");       // R1

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18:15]);
      check(VEC[i][14:8], int'(VEC[i][7:0]), $sformatf("vector %0d", i));
    end

    // coincident stop and sample enable while recording
    step(4'b1000);
    step(4'b0000);
    check(O_REC0, 3, "enter record");
    @(negedge clk);
    {rec, play, stop, en} = 4'b0011;
    #1 check(O_REC1, 6, "last strobe with stop");   // R6
    @(posedge clk); #2;
    check(O_IDLE, 8, "exit after last strobe");     // R8

    // asynchronous reset during play
    step(4'b0100);
    step(4'b0001);
    check(O_PLY1, 7, "play before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(O_IDLE, 1, "async reset mid play");    // R1
    {rec, play, stop, en} = 4'b0000;
    @(negedge clk) rst_n = 1'b1;
    step(4'b0000);
    check(O_IDLE, 2, "idle after reset release");   // R2

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule